// File: doc/BRIEF.md
# Wake Request Arbiter and Boot Sequencer

This block decides when a sleeping system may wake and walks it through a fixed boot sequence. Four wake requests come in: an aggregated power-good level, a watchdog early-warning interrupt, an alarm level and a manual key. Each request can be disabled by an enable mask. Power-good and key are filtered by stability counters before they count. When a permitted request appears, the sequencer leaves sleep and holds in a pending state. It stays there until a quiet inhibit window has elapsed without power-good instability. If the dual-confirm policy is on, it also waits until power-good and alarm are both present. It then reports the highest-priority cause that was seen while pending and steps through a minimal boot and a time-synchronisation phase. It reaches full run only after host acknowledgements.

Wakes that follow one another too closely are counted as repeats. A repeat is a wake accepted while the re-arm window of the previous wake is still open. A wake outside that window starts the count again. When the count reaches its limit, the lock policy decides the outcome. With lock off, the system is held in minimal boot. With lock on, the sequencer enters a lock state that only a host clear can leave. All timing parameters are counted in clock cycles, so a 32.768 kHz clock gives the default values of roughly 2 ms, 30 ms, 200 ms and 1 s.

Top module: `wake_seq`

## Requirements
- R1: The state output follows the order sleep (0), wake pending (1), minimal boot (2), time sync (3), run (4). Lock is code 5. Sleep moves to pending when any enabled filtered request is high.
- R2: The cause code is captured when pending is left. It names the highest-priority source among the requests seen during that pending stay. The codes are power-good 1, watchdog 2, alarm 3, key 4, with power-good first and key last. Cause is 0 after reset.
- R3: Pending advances only after INHIBIT+1 consecutive cycles in which enabled raw power-good agrees with its filtered level. Any disagreement restarts the window, so a jittering power-good keeps the system in pending and away from run.
- R4: Power-good changes its filtered level only after PG_DEB consecutive cycles at the new value. The key input needs KEY_DEB cycles. Shorter pulses cause no wake.
- R5: With dualConfirm high, pending advances only while filtered power-good and filtered alarm are both enabled and high.
- R6: A source whose wakeEn bit is 0 is ignored. The bit order is 0 power-good, 1 watchdog, 2 alarm, 3 key. Such a source causes no wake and contributes to neither the cause nor the inhibit condition.
- R7: Pending flags are cleared in the cycle pending is left, so a later wake reports only sources seen during that later stay.
- R8: A wake accepted after the previous wake's REARM-cycle window has closed resets the repeat count to zero.
- R9: With lockMode low, the wake that brings the repeat count to REPEAT_MAX is held in minimal boot. bootDone is ignored there until sleepReq.
- R10: With lockMode high, that wake goes from sleep straight to lock. Lock is left only by hostClear, which returns to sleep and clears the repeat count.
- R11: Minimal boot advances to time sync only on bootDone, and time sync advances to run only on timeValid.
- R12: sleepReq returns minimal boot, time sync or run to sleep.
- R13: After reset the state is sleep and the cause is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pgRaw | input | 1 | Aggregated power-good level, unfiltered |
| wdtRaw | input | 1 | Watchdog early-warning request |
| alarmRaw | input | 1 | Alarm request level |
| keyRaw | input | 1 | Manual key level, unfiltered |
| wakeEn | input | 4 | Per-source enable: bit 0 power-good, 1 watchdog, 2 alarm, 3 key |
| dualConfirm | input | 1 | Require power-good and alarm together to leave pending |
| lockMode | input | 1 | Repeat limit action: 0 hold in minimal boot, 1 lock |
| bootDone | input | 1 | Host acknowledge: minimal boot finished |
| timeValid | input | 1 | Host acknowledge: time is valid |
| sleepReq | input | 1 | Host request to return to sleep |
| hostClear | input | 1 | Host release of the lock state |
| state | output | 3 | Current sequencer state code |
| wakeCause | output | 3 | Cause code of the latest promotion |

## Verification
The hardest situation to reach from the ports is the repeat limit. Several complete wake cycles must fit inside one re-arm window, each passing through the inhibit wait before sleep can be requested again. The bench uses short cycle counts for every window, drops the request and issues sleepReq as soon as minimal boot is reached, and raises the next request at once. It does this under both lock policies, after a run of widely spaced wakes that must not count. Power-good jitter is produced by toggling the raw level faster than its filter depth, so the filtered level stays high while the inhibit window keeps restarting.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;

  localparam int NumSrc   = 4;
  localparam int SrcPg    = 0;
  localparam int SrcWdt   = 1;
  localparam int SrcAlarm = 2;
  localparam int SrcKey   = 3;

  typedef enum logic [2:0] {
    ST_SLEEP   = 3'd0,
    ST_PEND    = 3'd1,
    ST_BOOTMIN = 3'd2,
    ST_SYNC    = 3'd3,
    ST_RUN     = 3'd4,
    ST_LOCK    = 3'd5
  } wakeState_t;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_PG    = 3'd1,
    CAUSE_WDT   = 3'd2,
    CAUSE_ALARM = 3'd3,
    CAUSE_KEY   = 3'd4
  } wakeCause_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wakeEvt;    // wake accepted in sleep
    logic loadPend;   // start pending flags from current requests
    logic accumPend;  // merge current requests into pending flags
    logic promote;    // leave pending: capture cause, clear flags
    logic clrRepeat;  // host released the lock
  } wakeStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic anyReq;
    logic dualOk;
    logic pgJitter;
    logic inhibitDone;
    logic repeatHit;
    logic downgraded;
  } wakeStatus_t;

  function automatic wakeCause_t pickCause(input logic [NumSrc-1:0] flags);
    if (flags[SrcPg])         return CAUSE_PG;
    else if (flags[SrcWdt])   return CAUSE_WDT;
    else if (flags[SrcAlarm]) return CAUSE_ALARM;
    else if (flags[SrcKey])   return CAUSE_KEY;
    else                      return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/wake_debounce.sv
module wake_debounce #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic level
);
  localparam int CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic [CW-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level  <= 1'b0;
      runLen <= '0;
    end else if (rawIn == level) begin
      runLen <= '0;
    end else if (runLen == LAST) begin
      level  <= rawIn;
      runLen <= '0;
    end else begin
      runLen <= runLen + 1'b1;
    end
  end
endmodule

// File: rtl/wake_seq_datapath.sv
module wake_seq_datapath
  import wake_seq_pkg::*;
#(
  parameter int PG_DEB     = 66,
  parameter int KEY_DEB    = 984,
  parameter int INHIBIT    = 6554,
  parameter int REARM      = 32768,
  parameter int REPEAT_MAX = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumSrc-1:0] rawSrc,
  input  logic [NumSrc-1:0] wakeEn,
  input  wakeStrobe_t       strb,
  output wakeStatus_t       status,
  output logic [NumSrc-1:0] pendFlags,
  output wakeCause_t        cause
);
  localparam int IW = $clog2(INHIBIT + 1);
  localparam int RW = $clog2(REARM + 1);
  localparam int PW = $clog2(REPEAT_MAX + 1);
  localparam logic [IW-1:0] INH_TOP   = IW'(INHIBIT);
  localparam logic [RW-1:0] REARM_TOP = RW'(REARM);
  localparam logic [PW-1:0] REP_TOP   = PW'(REPEAT_MAX);

  logic [NumSrc-1:0] filtLvl;
  logic [NumSrc-1:0] req;

  for (genvar gi = 0; gi < NumSrc; gi++) begin : g_src
    localparam int Depth = (gi == SrcPg) ? PG_DEB : ((gi == SrcKey) ? KEY_DEB : 1);
    wake_debounce #(.DEPTH(Depth)) u_deb (
      .clk  (clk),
      .rstN (rstN),
      .rawIn(rawSrc[gi]),
      .level(filtLvl[gi])
    );
  end

  assign req = filtLvl & wakeEn;

  logic [IW-1:0] inhCnt;
  logic [RW-1:0] rearmLeft;
  logic [PW-1:0] repCnt;
  logic [PW-1:0] nextRep;
  logic          downFlag;

  always_comb begin
    if (rearmLeft != '0) nextRep = (repCnt == REP_TOP) ? REP_TOP : repCnt + 1'b1;
    else                 nextRep = '0;
  end

  always_comb begin
    status.anyReq      = |req;
    status.dualOk      = req[SrcPg] & req[SrcAlarm];
    status.pgJitter    = wakeEn[SrcPg] & (rawSrc[SrcPg] ^ filtLvl[SrcPg]);
    status.inhibitDone = (inhCnt == INH_TOP);
    status.repeatHit   = (nextRep == REP_TOP);
    status.downgraded  = downFlag;
  end

  // quiet-window counter, restarted by a new wake or by power-good jitter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                inhCnt <= '0;
    else if (strb.wakeEvt || status.pgJitter) inhCnt <= '0;
    else if (inhCnt != INH_TOP)               inhCnt <= inhCnt + 1'b1;
  end

  // re-arm window and repeat bookkeeping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rearmLeft <= '0;
      repCnt    <= '0;
      downFlag  <= 1'b0;
    end else begin
      if (strb.wakeEvt)          rearmLeft <= REARM_TOP;
      else if (rearmLeft != '0)  rearmLeft <= rearmLeft - 1'b1;
      if (strb.wakeEvt) begin
        repCnt   <= nextRep;
        downFlag <= status.repeatHit;
      end else if (strb.clrRepeat) begin
        repCnt   <= '0;
        downFlag <= 1'b0;
      end
    end
  end

  // pending flags and cause capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendFlags <= '0;
      cause     <= CAUSE_NONE;
    end else if (strb.promote) begin
      pendFlags <= '0;
      cause     <= pickCause(pendFlags | req);
    end else if (strb.loadPend) begin
      pendFlags <= req;
    end else if (strb.accumPend) begin
      pendFlags <= pendFlags | req;
    end
  end
endmodule

// File: rtl/wake_seq_ctrl.sv
module wake_seq_ctrl
  import wake_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  wakeStatus_t status,
  input  logic        dualConfirm,
  input  logic        lockMode,
  input  logic        bootDone,
  input  logic        timeValid,
  input  logic        sleepReq,
  input  logic        hostClear,
  output wakeState_t  state,
  output wakeStrobe_t strb
);
  wakeState_t nextState;
  logic       mayPromote;

  assign mayPromote = status.inhibitDone && !status.pgJitter &&
                      (!dualConfirm || status.dualOk);

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_SLEEP: if (status.anyReq) begin
        strb.wakeEvt = 1'b1;
        if (status.repeatHit && lockMode) begin
          nextState = ST_LOCK;
        end else begin
          nextState     = ST_PEND;
          strb.loadPend = 1'b1;
        end
      end
      ST_PEND: if (mayPromote) begin
        nextState    = ST_BOOTMIN;
        strb.promote = 1'b1;
      end else begin
        strb.accumPend = 1'b1;
      end
      ST_BOOTMIN: begin
        if (sleepReq)                            nextState = ST_SLEEP;
        else if (bootDone && !status.downgraded) nextState = ST_SYNC;
      end
      ST_SYNC: begin
        if (sleepReq)       nextState = ST_SLEEP;
        else if (timeValid) nextState = ST_RUN;
      end
      ST_RUN: if (sleepReq) nextState = ST_SLEEP;
      ST_LOCK: if (hostClear) begin
        nextState      = ST_SLEEP;
        strb.clrRepeat = 1'b1;
      end
      default: nextState = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SLEEP;
    else       state <= nextState;
  end
endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_seq_pkg::*;
#(
  parameter int PG_DEB     = 66,
  parameter int KEY_DEB    = 984,
  parameter int INHIBIT    = 6554,
  parameter int REARM      = 32768,
  parameter int REPEAT_MAX = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pgRaw,
  input  logic       wdtRaw,
  input  logic       alarmRaw,
  input  logic       keyRaw,
  input  logic [3:0] wakeEn,
  input  logic       dualConfirm,
  input  logic       lockMode,
  input  logic       bootDone,
  input  logic       timeValid,
  input  logic       sleepReq,
  input  logic       hostClear,
  output logic [2:0] state,
  output logic [2:0] wakeCause
);
  wakeStatus_t       stat;
  wakeStrobe_t       strb;
  wakeState_t        curState;
  wakeCause_t        causeV;
  logic [NumSrc-1:0] pendFlags;
  logic [NumSrc-1:0] rawSrc;

  assign rawSrc = {keyRaw, alarmRaw, wdtRaw, pgRaw};

  wake_seq_datapath #(
    .PG_DEB    (PG_DEB),
    .KEY_DEB   (KEY_DEB),
    .INHIBIT   (INHIBIT),
    .REARM     (REARM),
    .REPEAT_MAX(REPEAT_MAX)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .rawSrc   (rawSrc),
    .wakeEn   (wakeEn),
    .strb     (strb),
    .status   (stat),
    .pendFlags(pendFlags),
    .cause    (causeV)
  );

  wake_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .status     (stat),
    .dualConfirm(dualConfirm),
    .lockMode   (lockMode),
    .bootDone   (bootDone),
    .timeValid  (timeValid),
    .sleepReq   (sleepReq),
    .hostClear  (hostClear),
    .state      (curState),
    .strb       (strb)
  );

  assign state     = curState;
  assign wakeCause = causeV;
endmodule

// File: rtl/wake_seq_checker.sv
module wake_seq_checker
  import wake_seq_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  state,
  input logic [2:0]  wakeCause,
  input wakeStatus_t stat,
  input logic [3:0]  pendFlags,
  input logic        dualConfirm,
  input logic        sleepReq,
  input logic        hostClear,
  input logic        timeValid
);
  // R1: only pending leads into minimal boot
  p_enter_boot_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BOOTMIN && $past(state) != ST_BOOTMIN) |-> $past(state) == ST_PEND);

  // R6: no enabled request keeps sleep
  p_sleep_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && !stat.anyReq) |=> state == ST_SLEEP);

  // R3: jitter holds pending, and leaving needs a completed window
  p_jitter_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PEND && stat.pgJitter) |=> state == ST_PEND);
  p_window_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BOOTMIN && $past(state) == ST_PEND) |-> $past(stat.inhibitDone));

  // R5: dual confirmation missing holds pending
  p_dual_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PEND && dualConfirm && !stat.dualOk) |=> state == ST_PEND);

  // R7: no pending flag survives outside pending
  p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_PEND) |-> pendFlags == 4'b0);

  // R2: cause changes only at promotion and is then a real source
  p_cause_update_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wakeCause != $past(wakeCause)) |-> (state == ST_BOOTMIN && $past(state) == ST_PEND));
  p_cause_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BOOTMIN && $past(state) == ST_PEND) |-> (wakeCause != 3'd0 && wakeCause <= 3'd4));

  // R9: downgraded boot stays put without sleepReq
  p_down_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BOOTMIN && stat.downgraded && !sleepReq) |=> state == ST_BOOTMIN);

  // R10: lock entered only at the repeat limit, held until host clear
  p_lock_entry_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCK && $past(state) != ST_LOCK) |-> ($past(state) == ST_SLEEP && $past(stat.repeatHit)));
  p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCK && !hostClear) |=> state == ST_LOCK);

  // R11: run only from time sync with timeValid
  p_run_entry_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && $past(state) != ST_RUN) |-> ($past(state) == ST_SYNC && $past(timeValid)));
endmodule

bind wake_seq wake_seq_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .state      (state),
  .wakeCause  (wakeCause),
  .stat       (stat),
  .pendFlags  (pendFlags),
  .dualConfirm(dualConfirm),
  .sleepReq   (sleepReq),
  .hostClear  (hostClear),
  .timeValid  (timeValid)
);

// File: tb/wake_seq_tb.sv
module wake_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P_PG   = 4;
  localparam int P_KEY  = 6;
  localparam int P_INH  = 8;
  localparam int P_RARM = 60;
  localparam int P_REP  = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] raw = 4'b0;
  logic [3:0] wakeEn = 4'hF;
  logic       dualConfirm = 1'b0, lockMode = 1'b0, bootDone = 1'b0;
  logic       timeValid = 1'b0, sleepReq = 1'b0, hostClear = 1'b0;
  logic [2:0] state, wakeCause;

  wake_seq #(
    .PG_DEB(P_PG), .KEY_DEB(P_KEY), .INHIBIT(P_INH), .REARM(P_RARM), .REPEAT_MAX(P_REP)
  ) u_dut (
    .clk(clk), .rstN(rstN), .pgRaw(raw[0]), .wdtRaw(raw[1]), .alarmRaw(raw[2]),
    .keyRaw(raw[3]), .wakeEn(wakeEn), .dualConfirm(dualConfirm), .lockMode(lockMode),
    .bootDone(bootDone), .timeValid(timeValid), .sleepReq(sleepReq),
    .hostClear(hostClear), .state(state), .wakeCause(wakeCause)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference model
  int       mSt, mCause, mInh, mRearm, mRep;
  bit       mDown;
  bit [3:0] mFilt, mPend;
  int       mCnt[4];

  function automatic int depthOf(int i);
    if (i == 0) return P_PG;
    if (i == 3) return P_KEY;
    return 1;
  endfunction

  function automatic int prio(bit [3:0] f);
    if (f[0]) return 1;
    if (f[1]) return 2;
    if (f[2]) return 3;
    if (f[3]) return 4;
    return 0;
  endfunction

  task automatic stepModel();
    bit [3:0] req;
    bit jit, hit, wake, clr;
    int nRep, nSt, nCause;
    bit [3:0] nPend;
    req  = mFilt & wakeEn;
    jit  = wakeEn[0] && (raw[0] != mFilt[0]);
    nRep = (mRearm > 0) ? ((mRep >= P_REP) ? P_REP : mRep + 1) : 0;
    hit  = (nRep == P_REP);
    nSt = mSt; nCause = mCause; nPend = mPend; wake = 0; clr = 0;
    case (mSt)
      0: if (req != 0) begin
           wake = 1;
           if (hit && lockMode) nSt = 5;
           else begin nSt = 1; nPend = req; end
         end
      1: if (mInh == P_INH && !jit && (!dualConfirm || (req[0] && req[2]))) begin
           nSt = 2; nCause = prio(mPend | req); nPend = 0;
         end else nPend = mPend | req;
      2: if (sleepReq) nSt = 0; else if (bootDone && !mDown) nSt = 3;
      3: if (sleepReq) nSt = 0; else if (timeValid) nSt = 4;
      4: if (sleepReq) nSt = 0;
      5: if (hostClear) begin nSt = 0; clr = 1; end
      default: nSt = 0;
    endcase
    if (wake || jit) mInh = 0; else if (mInh < P_INH) mInh++;
    if (wake) mRearm = P_RARM; else if (mRearm > 0) mRearm--;
    if (wake) begin mRep = nRep; mDown = hit; end
    else if (clr) begin mRep = 0; mDown = 0; end
    for (int i = 0; i < 4; i++) begin
      if (raw[i] == mFilt[i]) mCnt[i] = 0;
      else if (mCnt[i] == depthOf(i) - 1) begin mFilt[i] = raw[i]; mCnt[i] = 0; end
      else mCnt[i]++;
    end
    mSt = nSt; mCause = nCause; mPend = nPend;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 0; mCause = 0; mInh = 0; mRearm = 0; mRep = 0; mDown = 0;
      mFilt = 0; mPend = 0;
      for (int i = 0; i < 4; i++) mCnt[i] = 0;
    end else stepModel();
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks += 2;
      if (state !== mSt[2:0]) begin
        fails++;
        $display("FAIL R1 model state act=%0d exp=%0d t=%0t", state, mSt, $time);
      end
      if (wakeCause !== mCause[2:0]) begin
        fails++;
        $display("FAIL R2 model cause act=%0d exp=%0d t=%0t", wakeCause, mCause, $time);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitState(input int s, input int lim);
    for (int k = 0; k < lim && state != s[2:0]; k++) tick(1);
  endtask

  task automatic pulseSleep();
    sleepReq = 1; tick(1); sleepReq = 0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL R1 watchdog expired act=%0d exp=done", state);
    finishRun();
  end

  initial begin
    tick(3);
    rstN = 1;
    tick(2);
    check("R13 reset state", state, 0);
    check("R13 reset cause", wakeCause, 0);

    // R4: short pulses below filter depth
    raw[3] = 1; tick(P_KEY - 2); raw[3] = 0; tick(20);
    check("R4 short key pulse", state, 0);
    raw[0] = 1; tick(P_PG - 2); raw[0] = 0; tick(10);
    check("R4 short pg pulse", state, 0);

    // R1/R2/R11/R12: full sequence, watchdog and alarm together
    raw[1] = 1; raw[2] = 1;
    waitState(2, 60);
    check("R1 reach minimal boot", state, 2);
    check("R2 watchdog beats alarm", wakeCause, 2);
    raw[1] = 0; raw[2] = 0;
    bootDone = 1; tick(1); bootDone = 0;
    check("R11 bootDone to sync", state, 3);
    tick(5);
    check("R11 sync holds without timeValid", state, 3);
    timeValid = 1; tick(1); timeValid = 0;
    check("R1 run reached", state, 4);
    pulseSleep();
    check("R12 sleep from run", state, 0);
    tick(80);

    // R7: later key wake reports only the key
    raw[3] = 1;
    waitState(2, 60);
    check("R7 stale flags cleared", wakeCause, 4);
    raw[3] = 0; tick(P_KEY + 2);
    pulseSleep();
    check("R12 sleep from minimal boot", state, 0);
    tick(80);

    // R6: masked alarm ignored
    wakeEn = 4'b1011;
    raw[2] = 1; tick(30);
    check("R6 masked alarm no wake", state, 0);
    raw[2] = 0; tick(2); wakeEn = 4'hF; tick(2);

    // R3: power-good jitter keeps pending
    raw[0] = 1;
    waitState(1, 20);
    check("R3 pending entered", state, 1);
    for (int j = 0; j < 10; j++) begin
      raw[0] = 0; tick(2); raw[0] = 1; tick(2);
    end
    check("R3 jitter holds pending", state, 1);
    waitState(2, 40);
    check("R3 promote after quiet window", state, 2);
    check("R2 power-good cause", wakeCause, 1);
    raw[0] = 0; tick(P_PG + 2);
    pulseSleep();
    tick(80);

    // R5: dual confirm
    dualConfirm = 1;
    raw[2] = 1;
    waitState(1, 10);
    tick(30);
    check("R5 alarm alone held", state, 1);
    raw[0] = 1;
    waitState(2, 40);
    check("R5 both present promotes", state, 2);
    check("R2 power-good over alarm", wakeCause, 1);
    raw = 0; dualConfirm = 0; tick(P_PG + 2);
    pulseSleep();
    tick(80);

    // R8: spaced wakes never count as repeats
    lockMode = 1;
    for (int k = 0; k < 3; k++) begin
      raw[2] = 1;
      waitState(2, 40);
      check("R8 spaced wake boots", state, 2);
      raw[2] = 0; tick(2);
      pulseSleep();
      tick(80);
    end

    // R9: quick repeats downgrade with lock off
    lockMode = 0;
    for (int k = 0; k < 3; k++) begin
      raw[2] = 1;
      waitState(2, 40);
      raw[2] = 0; tick(2);
      if (k == 2) begin
        bootDone = 1; tick(1); bootDone = 0; tick(5);
        check("R9 downgraded ignores bootDone", state, 2);
      end
      pulseSleep();
    end
    tick(80);
    raw[2] = 1;
    waitState(2, 40);
    raw[2] = 0;
    bootDone = 1; tick(1); bootDone = 0;
    check("R8 count restarts after window", state, 3);
    pulseSleep();
    check("R12 sleep from sync", state, 0);
    tick(80);

    // R10: quick repeats lock with lock on
    lockMode = 1;
    for (int k = 0; k < 3; k++) begin
      raw[2] = 1;
      waitState((k == 2) ? 5 : 2, 40);
      if (k < 2) begin
        raw[2] = 0; tick(2);
        pulseSleep();
      end
    end
    check("R10 lock entered", state, 5);
    raw[2] = 0; tick(4); raw[2] = 1; tick(10);
    check("R10 lock holds", state, 5);
    raw[2] = 0; tick(3);
    hostClear = 1; tick(1); hostClear = 0;
    check("R10 host clear to sleep", state, 0);
    tick(5);

    finishRun();
  end
endmodule